// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit is the write gatekeeper for a small serial non-volatile memory. It holds the write enable latch and the three protect bits of the status register. For any byte address on its check port, it reports in the same cycle whether a write there is currently permitted. A command decoder feeds it single-cycle events for enable, disable and status write, plus a pulse when chip select rises. The write engine reports when an internal programming cycle is running and when it finishes. The unit also watches the active-low write-protect pin.

An enable command is only armed when it is decoded. The latch sets at the next chip-select rise, so a write within the same select period is refused. A status write is held pending until chip select rises, and the internal cycle starts there. The new protect code takes effect when the engine signals done. A falling write-protect pin cancels the pending status write only before that rise. Every completed internal cycle returns the unit to the write-disabled state.

All ports are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies and the unit never applies back-pressure. Events are accepted in any cycle in which they are asserted.

Top module: `wprot_unit`

## Requirements
- R1: After reset the latch is clear, the status byte is 8'h00 and no write is allowed.
- R2: An enable event arms the latch, and the latch sets only on a later chip-select rise. Until that rise, both the latch and the write-allowed flag remain low.
- R3: A disable event clears the latch. A disable between an enable and the chip-select rise cancels the armed enable.
- R4: When the engine is idle, the status byte is {5'b00000, code[2:0]}. While the engine is busy, it reads 8'hFF.
- R5: The protect code maps to regions as follows. 0 protects nothing. Codes 1 to 4 protect the quarter whose top two address bits equal code-1. Code 5 protects addresses whose top bit is 0. Code 6 protects the first page, where the address bits above the page offset are all zero. Code 7 protects the last page, where those bits are all ones. A protected address never gives write-allowed.
- R6: While wp_n is low, write-allowed is low for every address.
- R7: A wp_n fall after a status write event and before the chip-select rise discards the new code. A wp_n fall after the rise does not stop the code from being loaded at done.
- R8: A status write event is ignored when the latch is clear. Only bits 2:0 of the written byte are stored.
- R9: An engine done pulse clears the latch. It also loads the status code that was started at the last accepted chip-select rise.
- R10: While the engine is busy, enable, disable and status write events are ignored, and write-allowed is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_evt | input | 1 | Decoded write-enable command, one cycle |
| wrdi_evt | input | 1 | Decoded write-disable command, one cycle |
| wrsr_evt | input | 1 | Decoded status-write with its data byte, one cycle |
| wrsr_byte | input | 8 | Data byte of the status write |
| cs_rise_evt | input | 1 | Chip select went high, one cycle |
| wp_n | input | 1 | Write-protect pin, low inhibits writes |
| chk_addr | input | ADDR_W | Byte address to check |
| eng_busy | input | 1 | Internal programming cycle in progress |
| eng_done | input | 1 | Internal programming cycle finished, one cycle |
| status_byte | output | 8 | Status register image |
| wr_ok | output | 1 | Write to chk_addr is allowed |
| wel | output | 1 | Write enable latch state |

## Verification
The bench instantiates the unit with ADDR_W=8 and PAGE_BYTES=16, which gives a 256-byte array with sixteen pages. With that size, a sweep over every address under every protect code finishes in a few thousand cycles. Every region boundary, including both ends of the first and last pages, is therefore checked against range arithmetic written in the bench. The small page also places the page boundary at a low address bit, distinct from the quarter boundary bits.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    PR_NONE     = 3'd0,
    PR_QTR0     = 3'd1,
    PR_QTR1     = 3'd2,
    PR_QTR2     = 3'd3,
    PR_QTR3     = 3'd4,
    PR_LOWHALF  = 3'd5,
    PR_FIRSTPG  = 3'd6,
    PR_LASTPG   = 3'd7
  } prot_code_e;

  localparam logic [7:0] STATUS_BUSY = 8'hFF;
endpackage

// File: rtl/wprot_latch.sv
module wprot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_evt,
  input  logic wrdi_evt,
  input  logic cs_rise_evt,
  input  logic eng_busy,
  input  logic eng_done,
  output logic wel
);
  logic armed;
  logic take_wren, take_wrdi;

  assign take_wren = wren_evt & ~eng_busy;
  assign take_wrdi = wrdi_evt & ~eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      wel   <= 1'b0;
    end else begin
      if (take_wrdi || cs_rise_evt) armed <= 1'b0;
      else if (take_wren)           armed <= 1'b1;

      if (eng_done)                    wel <= 1'b0;
      else if (take_wrdi)              wel <= 1'b0;
      else if (cs_rise_evt && armed)   wel <= 1'b1;
    end
  end

  a_r2_set_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise_evt));
  a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wrdi_evt && !eng_busy) |=> !wel);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !wel);
  a_r10_no_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(eng_busy));
endmodule

// File: rtl/wprot_status.sv
module wprot_status
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrsr_evt,
  input  logic [2:0] wrsr_code,
  input  logic       wel,
  input  logic       wp_n,
  input  logic       cs_rise_evt,
  input  logic       eng_busy,
  input  logic       eng_done,
  output prot_code_e code,
  output logic [7:0] status_byte
);
  logic       wp_q, wp_fall;
  logic       pend_vld, fly_vld;
  logic [2:0] pend_code, fly_code;

  assign wp_fall = wp_q & ~wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q      <= 1'b0;
      pend_vld  <= 1'b0;
      pend_code <= 3'd0;
      fly_vld   <= 1'b0;
      fly_code  <= 3'd0;
      code      <= PR_NONE;
    end else begin
      wp_q <= wp_n;
      // pending stage: accepted before chip select rises, abortable by WP
      if (cs_rise_evt || wp_fall) begin
        pend_vld <= 1'b0;
      end else if (wrsr_evt && wel && wp_n && !eng_busy) begin
        pend_vld  <= 1'b1;
        pend_code <= wrsr_code;
      end
      // in-flight stage: cycle started, WP no longer matters
      if (eng_done) begin
        fly_vld <= 1'b0;
        if (fly_vld) code <= prot_code_e'(fly_code);
      end else if (cs_rise_evt && pend_vld && !wp_fall && wp_n) begin
        fly_vld  <= 1'b1;
        fly_code <= pend_code;
      end
    end
  end

  assign status_byte = eng_busy ? STATUS_BUSY : {5'b00000, code};

  a_r9_code_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> $past(eng_done));
  a_r7_fall_kills_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_fall && !eng_done) |=> !pend_vld);
endmodule

// File: rtl/wprot_region.sv
module wprot_region
  import wprot_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  prot_code_e        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int HI_W = ADDR_W - PG_W;

  logic [1:0]      qtr;
  logic [HI_W-1:0] page_no;
  logic [PG_W-1:0] unused_offset;

  assign qtr           = addr[ADDR_W-1 -: 2];
  assign page_no       = addr[ADDR_W-1:PG_W];
  assign unused_offset = addr[PG_W-1:0];

  always_comb begin
    unique case (code)
      PR_NONE:    hit = 1'b0;
      PR_QTR0:    hit = (qtr == 2'd0);
      PR_QTR1:    hit = (qtr == 2'd1);
      PR_QTR2:    hit = (qtr == 2'd2);
      PR_QTR3:    hit = (qtr == 2'd3);
      PR_LOWHALF: hit = ~addr[ADDR_W-1];
      PR_FIRSTPG: hit = (page_no == '0);
      PR_LASTPG:  hit = &page_no;
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
  import wprot_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_evt,
  input  logic              wrdi_evt,
  input  logic              wrsr_evt,
  input  logic [7:0]        wrsr_byte,
  input  logic              cs_rise_evt,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic [7:0]        status_byte,
  output logic              wr_ok,
  output logic              wel
);
  prot_code_e code;
  logic       hit;
  logic [4:0] unused_wrsr_hi;

  assign unused_wrsr_hi = wrsr_byte[7:3];

  wprot_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wren_evt(wren_evt), .wrdi_evt(wrdi_evt),
    .cs_rise_evt(cs_rise_evt), .eng_busy(eng_busy), .eng_done(eng_done),
    .wel(wel));

  wprot_status u_status (
    .clk(clk), .rst_n(rst_n), .wrsr_evt(wrsr_evt), .wrsr_code(wrsr_byte[2:0]),
    .wel(wel), .wp_n(wp_n), .cs_rise_evt(cs_rise_evt), .eng_busy(eng_busy),
    .eng_done(eng_done), .code(code), .status_byte(status_byte));

  wprot_region #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_region (
    .code(code), .addr(chk_addr), .hit(hit));

  assign wr_ok = wel & wp_n & ~eng_busy & ~hit;

  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> !wr_ok);
  a_r2_ok_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> wel);
endmodule

// File: tb/test_wprot_unit.sv
module test_wprot_unit;
  localparam int AW = 8;
  localparam int PB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_evt = 0, wrdi_evt = 0, wrsr_evt = 0, cs_rise_evt = 0;
  logic wp_n = 1, eng_busy = 0, eng_done = 0;
  logic [7:0] wrsr_byte = 8'h00;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0] status_byte;
  logic wr_ok, wel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wprot_unit #(.ADDR_W(AW), .PAGE_BYTES(PB)) i_wprot_unit (
    .clk(clk), .rst_n(rst_n), .wren_evt(wren_evt), .wrdi_evt(wrdi_evt),
    .wrsr_evt(wrsr_evt), .wrsr_byte(wrsr_byte), .cs_rise_evt(cs_rise_evt),
    .wp_n(wp_n), .chk_addr(chk_addr), .eng_busy(eng_busy), .eng_done(eng_done),
    .status_byte(status_byte), .wr_ok(wr_ok), .wel(wel));

  // code, address, expected wr_ok with the latch set
  localparam logic [11:0] VEC [0:15] = '{
    {3'd0, 8'h00, 1'b1}, {3'd1, 8'h3F, 1'b0}, {3'd1, 8'h40, 1'b1},
    {3'd2, 8'h40, 1'b0}, {3'd2, 8'hBF, 1'b1}, {3'd3, 8'h80, 1'b0},
    {3'd3, 8'h7F, 1'b1}, {3'd4, 8'hFF, 1'b0}, {3'd4, 8'hBF, 1'b1},
    {3'd5, 8'h7F, 1'b0}, {3'd5, 8'h80, 1'b1}, {3'd6, 8'h0F, 1'b0},
    {3'd6, 8'h10, 1'b1}, {3'd7, 8'hF0, 1'b0}, {3'd7, 8'hEF, 1'b1},
    {3'd4, 8'hC0, 1'b0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ev_wren();  wren_evt = 1; tick(); wren_evt = 0; endtask
  task automatic ev_wrdi();  wrdi_evt = 1; tick(); wrdi_evt = 0; endtask
  task automatic ev_rise();  cs_rise_evt = 1; tick(); cs_rise_evt = 0; endtask
  task automatic ev_wrsr(input logic [7:0] b);
    wrsr_byte = b; wrsr_evt = 1; tick(); wrsr_evt = 0;
  endtask
  task automatic engine_cycle();
    eng_busy = 1; tick(); tick();
    eng_done = 1; tick();
    eng_done = 0; eng_busy = 0; tick();
  endtask
  task automatic enable(); ev_wren(); ev_rise(); endtask
  task automatic set_code(input logic [2:0] c);
    enable(); ev_wrsr({5'b10101, c}); ev_rise(); engine_cycle();
  endtask

  function automatic bit in_region(int c, int a);
    case (c)
      1, 2, 3, 4: return (a >= (c - 1) * 64) && (a <= (c - 1) * 64 + 63);
      5: return a < 128;
      6: return a < PB;
      7: return a >= 256 - PB;
      default: return 0;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 wel", wel, 0);
    check("R1 status", status_byte, 8'h00);
    check("R1 wr_ok", wr_ok, 0);

    // R2 enable needs chip-select rise
    ev_wren();
    check("R2 wel before rise", wel, 0);
    check("R2 wr_ok before rise", wr_ok, 0);
    ev_rise();
    check("R2 wel after rise", wel, 1);
    check("R2 wr_ok after rise", wr_ok, 1);

    // R3 disable clears and cancels armed enable
    ev_wrdi();
    check("R3 wrdi clears", wel, 0);
    ev_wren(); ev_wrdi(); ev_rise();
    check("R3 armed enable cancelled", wel, 0);

    // R4 / R10 busy behaviour
    enable(); ev_wrsr(8'h02); ev_rise();
    eng_busy = 1; tick();
    check("R4 busy status", status_byte, 8'hFF);
    check("R10 wr_ok low while busy", wr_ok, 0);
    ev_wrdi();
    check("R10 wrdi ignored while busy", wel, 1);
    eng_done = 1; tick(); eng_done = 0; eng_busy = 0; tick();
    // R9 done clears latch and loads code
    check("R9 latch cleared by done", wel, 0);
    check("R4 R9 status code", status_byte, 8'h02);
    eng_busy = 1; ev_wren(); ev_rise(); eng_busy = 0; tick();
    check("R10 wren ignored while busy", wel, 0);

    // R5 vector table
    foreach (VEC[i]) begin
      set_code(VEC[i][11:9]);
      enable();
      chk_addr = VEC[i][8:1]; #1;
      check($sformatf("R5 vec%0d", i), wr_ok, VEC[i][0]);
    end

    // R5 full sweep per code
    for (int c = 0; c < 8; c++) begin
      int bad = 0;
      set_code(c[2:0]);
      enable();
      for (int a = 0; a < 256; a++) begin
        chk_addr = a[7:0]; #1;
        if (wr_ok !== !in_region(c, a)) bad++;
      end
      check($sformatf("R5 sweep code %0d mismatches", c), bad[7:0], 8'd0);
      ev_wrdi();
    end

    // R6 WP low blocks writes
    set_code(3'd0); enable(); chk_addr = 8'h55;
    wp_n = 0; tick();
    check("R6 wp low", wr_ok, 0);
    wp_n = 1; tick();
    check("R6 wp high again", wr_ok, 1);

    // R7 WP fall before rise discards status write
    ev_wrsr(8'h05); wp_n = 0; tick(); wp_n = 1; tick();
    ev_rise(); engine_cycle();
    check("R7 aborted before rise", status_byte, 8'h00);
    enable(); ev_wrsr(8'h03); ev_rise();
    wp_n = 0; engine_cycle(); wp_n = 1; tick();
    check("R7 fall after rise has no effect", status_byte, 8'h03);

    // R8 ignored without latch, upper bits dropped
    ev_wrsr(8'h07); ev_rise(); engine_cycle();
    check("R8 ignored without latch", status_byte, 8'h03);
    enable(); ev_wrsr(8'hFE); ev_rise(); engine_cycle();
    check("R8 only low bits kept", status_byte, 8'h06);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule